// File: doc/BRIEF.md
# Escalating Watchdog with Periodic Timer

This block pairs a programmable tick timer with a watchdog that counts the timer's expirations. Each time the watchdog expires, it moves one stage further along a fixed escalation ladder. The ladder starts with an interrupt, moves on to a fast interrupt and a remote interrupt, then a debug reset, and ends in a power-on reset. Each stage's output stays asserted until software stops the watchdog. Software services the watchdog with a "pet": a disable command followed by a start command, which sends the ladder back to its first stage.

A host reaches the registers over a simple single-cycle register bus. Writes take effect on the clock edge. Reads are combinational from the address. A one-cycle strobe on `usTick` marks each microsecond and advances the timer. A disable command is honoured only when the unlock register received the key value beforehand. That unlock is used up by the next command write, so stray writes cannot silence the watchdog.

Register map (byte offsets):
- 0x00: watchdog config
- 0x04: command
- 0x08: unlock
- 0x10: timer control
- 0x14: timer status
- 0x18: timer clock-source select
- 0x20: shared interrupt mask

Top module: `wdt_escalator`

## Requirements
- R1: After reset, every output is low and every readable register (0x00, 0x10, 0x14, 0x18, 0x20) reads zero.
- R2: With timer control bit 31 set, source select 0 and period P in bits [27:0], the timer expires on every P-th tick (P=0 acts as 1). Each expiry sets timer status bit 30, and writing 1 to status bit 30 clears it.
- R3: With control bit 30 (periodic) clear, an expiry clears control bit 31, so the timer stops. With bit 30 set, bit 31 stays set and the timer reloads.
- R4: A non-zero value in the source-select register makes the timer ignore `usTick`.
- R5: The watchdog counts timer expirations only after a start command (command bit 0). It counts them only while config bits [3:0] equal the timer's index (0). It expires once every N timer expirations, where N is config bits [11:4] and N=0 acts as 1.
- R6: The ladder escalates one stage per watchdog expiry. Stage 1 asserts `irqOut`. Stage 2 adds `fiqOut` and `remoteIrqOut`. Stage 3 adds nothing. Stage 4 adds `dbgResetOut`. Stage 5 adds `porResetOut`.
- R7: Each output is gated by its own config enable bit: bit 12 `irqOut`, bit 13 `fiqOut`, bit 14 `remoteIrqOut`, bit 15 `dbgResetOut`, bit 16 `porResetOut`.
- R8: `irqOut` is further gated by bit 16+4×index (bit 16 for index 0) of the interrupt mask register at 0x20.
- R9: A disable command (command bit 1) written without a prior unlock has no effect: outputs and counting carry on.
- R10: Writing 0x0000C45A to the unlock register and then issuing a disable clears the stage, the watchdog divider and the timer count, and stops counting. A following start (or bits 0 and 1 in one write) restarts escalation from stage 1 with a fresh timer period.
- R11: Any command write consumes the unlock. Any other value written to the unlock register re-locks the watchdog.
- R12: Once at stage 5, further expiries leave the stage at 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| usTick | input | 1 | One-cycle microsecond tick |
| irqOut | output | 1 | Local interrupt (stage 1) |
| fiqOut | output | 1 | Fast interrupt (stage 2) |
| remoteIrqOut | output | 1 | Remote interrupt (stage 2) |
| dbgResetOut | output | 1 | Debug reset request (stage 4) |
| porResetOut | output | 1 | Power-on reset request (stage 5) |

## Verification
A register write takes effect on the edge where `busWrEn` is sampled. A tick that completes a timer period sets status, escalates the stage and updates the outputs on that same edge, because the outputs decode the stage register directly. The bench drives every stimulus at a falling edge and holds it for one cycle. It then samples at the next falling edge, half a cycle after the edge that carried the effect. Read data is combinational, so the bench samples it 1 ns after the address settles.

// File: rtl/wdt_escalator_pkg.sv
package wdt_escalator_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int PERIOD_W   = 28;
  localparam int DIV_W      = 8;
  localparam int SRC_W      = 4;
  localparam int NUM_OUT    = 5;
  localparam int WDCFG_W    = 17;

  localparam logic [ADDR_W-1:0] A_WD_CFG   = 8'h00;
  localparam logic [ADDR_W-1:0] A_WD_CMD   = 8'h04;
  localparam logic [ADDR_W-1:0] A_WD_UNLK  = 8'h08;
  localparam logic [ADDR_W-1:0] A_TMR_CTRL = 8'h10;
  localparam logic [ADDR_W-1:0] A_TMR_STAT = 8'h14;
  localparam logic [ADDR_W-1:0] A_TMR_SRC  = 8'h18;
  localparam logic [ADDR_W-1:0] A_IRQ_MASK = 8'h20;

  typedef enum logic [2:0] {
    STG_IDLE = 3'd0,
    STG_IRQ  = 3'd1,
    STG_FIQ  = 3'd2,
    STG_HOLD = 3'd3,
    STG_DBG  = 3'd4,
    STG_POR  = 3'd5
  } stage_t;

  // strobes from the register control to the counting datapath
  typedef struct packed {
    logic clearCounts;
    logic runClear;
    logic runSet;
  } wdtStrobe_t;

  // static configuration seen by the datapath
  typedef struct packed {
    logic                 tmrEnable;
    logic                 tickSel;
    logic [PERIOD_W-1:0]  tmrPeriod;
    logic                 wdSrcMatch;
    logic [DIV_W-1:0]     wdPeriods;
    logic [NUM_OUT-1:0]   outEn;
    logic                 maskOn;
  } wdtCfg_t;
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_escalator_pkg::*;
#(
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_C45A,
  parameter int                WD_INDEX   = 0,
  parameter int                TMR_INDEX  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              tmrExpire,
  output wdtCfg_t           cfg,
  output wdtStrobe_t        strobe
);
  localparam int MASK_BIT   = 16 + 4 * WD_INDEX;
  localparam int EN_LSB     = 12;
  localparam int DIV_LSB    = 4;
  localparam int T_EN_BIT   = 31;
  localparam int T_PER_BIT  = 30;
  localparam int T_CLR_BIT  = 30;
  localparam int C_START    = 0;
  localparam int C_STOP     = 1;

  logic                 tmrEnableQ;
  logic                 tmrPeriodicQ;
  logic [PERIOD_W-1:0]  tmrPeriodQ;
  logic                 tmrPendQ;
  logic [SRC_W-1:0]     tmrSrcQ;
  logic [WDCFG_W-1:0]   wdCfgQ;
  logic                 unlockedQ;
  logic [DATA_W-1:0]    maskQ;

  logic cmdWr;
  logic ctrlWr;
  assign cmdWr  = busWrEn && (busAddr == A_WD_CMD);
  assign ctrlWr = busWrEn && (busAddr == A_TMR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrEnableQ   <= 1'b0;
      tmrPeriodicQ <= 1'b0;
      tmrPeriodQ   <= '0;
      tmrPendQ     <= 1'b0;
      tmrSrcQ      <= '0;
      wdCfgQ       <= '0;
      unlockedQ    <= 1'b0;
      maskQ        <= '0;
    end else begin
      if (tmrExpire && !tmrPeriodicQ) tmrEnableQ <= 1'b0;
      if (busWrEn && busAddr == A_TMR_STAT && busWrData[T_CLR_BIT]) tmrPendQ <= 1'b0;
      if (tmrExpire) tmrPendQ <= 1'b1;
      if (busWrEn) begin
        case (busAddr)
          A_TMR_CTRL: begin
            tmrEnableQ   <= busWrData[T_EN_BIT];
            tmrPeriodicQ <= busWrData[T_PER_BIT];
            tmrPeriodQ   <= busWrData[PERIOD_W-1:0];
          end
          A_TMR_SRC:  tmrSrcQ   <= busWrData[SRC_W-1:0];
          A_WD_CFG:   wdCfgQ    <= busWrData[WDCFG_W-1:0];
          A_WD_UNLK:  unlockedQ <= (busWrData == UNLOCK_KEY);
          A_WD_CMD:   unlockedQ <= 1'b0;
          A_IRQ_MASK: maskQ     <= busWrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.clearCounts = cmdWr && busWrData[C_STOP] && unlockedQ;
    strobe.runClear    = strobe.clearCounts;
    strobe.runSet      = cmdWr && busWrData[C_START];
  end

  always_comb begin
    cfg.tmrEnable  = tmrEnableQ;
    cfg.tickSel    = (tmrSrcQ == '0);
    cfg.tmrPeriod  = tmrPeriodQ;
    cfg.wdSrcMatch = (wdCfgQ[SRC_W-1:0] == SRC_W'(TMR_INDEX));
    cfg.wdPeriods  = wdCfgQ[DIV_LSB +: DIV_W];
    cfg.outEn      = wdCfgQ[EN_LSB +: NUM_OUT];
    cfg.maskOn     = maskQ[MASK_BIT];
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      A_TMR_CTRL: begin
        busRdData[T_EN_BIT]       = tmrEnableQ;
        busRdData[T_PER_BIT]      = tmrPeriodicQ;
        busRdData[PERIOD_W-1:0]   = tmrPeriodQ;
      end
      A_TMR_STAT: busRdData[T_CLR_BIT]     = tmrPendQ;
      A_TMR_SRC:  busRdData[SRC_W-1:0]     = tmrSrcQ;
      A_WD_CFG:   busRdData[WDCFG_W-1:0]   = wdCfgQ;
      A_IRQ_MASK: busRdData                = maskQ;
      default:    busRdData                = '0;
    endcase
  end

  // R11
  unlock_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlockedQ) |-> $past(busWrEn && busAddr == A_WD_UNLK && busWrData == UNLOCK_KEY));

  // R3
  oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tmrExpire && !tmrPeriodicQ && !ctrlWr) |=> !tmrEnableQ);
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core
  import wdt_escalator_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  wdtCfg_t    cfg,
  input  wdtStrobe_t strobe,
  output logic       tmrExpire,
  output logic       irqOut,
  output logic       fiqOut,
  output logic       remoteIrqOut,
  output logic       dbgResetOut,
  output logic       porResetOut
);
  logic [PERIOD_W-1:0] tmrCntQ;
  logic [DIV_W-1:0]    divCntQ;
  logic                runQ;
  stage_t              stageQ;

  logic [PERIOD_W-1:0] tmrLast;
  logic [DIV_W-1:0]    divLast;
  logic                tickEn;
  logic                wdCount;
  logic                wdExpire;

  assign tmrLast   = (cfg.tmrPeriod == '0) ? '0 : cfg.tmrPeriod - PERIOD_W'(1);
  assign divLast   = (cfg.wdPeriods == '0) ? '0 : cfg.wdPeriods - DIV_W'(1);
  assign tickEn    = usTick && cfg.tmrEnable && cfg.tickSel;
  assign tmrExpire = tickEn && (tmrCntQ >= tmrLast);
  assign wdCount   = tmrExpire && runQ && cfg.wdSrcMatch;
  assign wdExpire  = wdCount && (divCntQ >= divLast);

  function automatic stage_t stepStage(stage_t s);
    case (s)
      STG_IDLE: return STG_IRQ;
      STG_IRQ:  return STG_FIQ;
      STG_FIQ:  return STG_HOLD;
      STG_HOLD: return STG_DBG;
      default:  return STG_POR;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrCntQ <= '0;
    end else if (strobe.clearCounts || !cfg.tmrEnable) begin
      tmrCntQ <= '0;
    end else if (tickEn) begin
      tmrCntQ <= tmrExpire ? '0 : tmrCntQ + PERIOD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      divCntQ <= '0;
      stageQ  <= STG_IDLE;
    end else begin
      if (strobe.runClear) runQ <= 1'b0;
      if (strobe.runSet)   runQ <= 1'b1;
      if (strobe.clearCounts) begin
        divCntQ <= '0;
        stageQ  <= STG_IDLE;
      end else if (wdCount) begin
        divCntQ <= wdExpire ? '0 : divCntQ + DIV_W'(1);
        if (wdExpire) stageQ <= stepStage(stageQ);
      end
    end
  end

  always_comb begin
    irqOut       = (stageQ >= STG_IRQ) && cfg.outEn[0] && cfg.maskOn;
    fiqOut       = (stageQ >= STG_FIQ) && cfg.outEn[1];
    remoteIrqOut = (stageQ >= STG_FIQ) && cfg.outEn[2];
    dbgResetOut  = (stageQ >= STG_DBG) && cfg.outEn[3];
    porResetOut  = (stageQ == STG_POR) && cfg.outEn[4];
  end

  // R12
  stage_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stageQ == STG_POR && !strobe.clearCounts) |=> stageQ == STG_POR);

  // R6
  stage_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearCounts |=> (int'(stageQ) == int'($past(stageQ)) ||
                             int'(stageQ) == int'($past(stageQ)) + 1));

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCounts |=> (stageQ == STG_IDLE && tmrCntQ == '0 && divCntQ == '0));

  // R6
  por_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(porResetOut) |-> ($past(stageQ) == STG_DBG || $past(stageQ) == STG_POR));
endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
  import wdt_escalator_pkg::*;
#(
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_C45A,
  parameter int                WD_INDEX   = 0,
  parameter int                TMR_INDEX  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              usTick,
  output logic              irqOut,
  output logic              fiqOut,
  output logic              remoteIrqOut,
  output logic              dbgResetOut,
  output logic              porResetOut
);
  wdtCfg_t    cfg;
  wdtStrobe_t strobe;
  logic       tmrExpire;

  wdt_ctrl_regs #(
    .UNLOCK_KEY (UNLOCK_KEY),
    .WD_INDEX   (WD_INDEX),
    .TMR_INDEX  (TMR_INDEX)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .tmrExpire (tmrExpire),
    .cfg       (cfg),
    .strobe    (strobe)
  );

  wdt_count_core u_core (
    .clk          (clk),
    .rstN         (rstN),
    .usTick       (usTick),
    .cfg          (cfg),
    .strobe       (strobe),
    .tmrExpire    (tmrExpire),
    .irqOut       (irqOut),
    .fiqOut       (fiqOut),
    .remoteIrqOut (remoteIrqOut),
    .dbgResetOut  (dbgResetOut),
    .porResetOut  (porResetOut)
  );
endmodule

// File: tb/wdt_escalator_bench.sv
module wdt_escalator_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h0000_C45A;
  localparam logic [7:0] A_CFG = 8'h00, A_CMD = 8'h04, A_UNLK = 8'h08,
                         A_TCTL = 8'h10, A_TSTAT = 8'h14, A_TSRC = 8'h18, A_MASK = 8'h20;
  localparam logic [31:0] T_EN = 32'h8000_0000, T_PER = 32'h4000_0000;
  localparam logic [31:0] ALL_EN = 32'h0001_F000;

  // vector table: timer period, watchdog divider, enable bits [4:0] (cfg bits 16..12),
  // mask bit, number of ticks, expected {por,dbg,remote,fiq,irq}
  localparam int NUM_VEC = 10;
  localparam int          V_PER  [NUM_VEC] = '{3, 2, 1, 4, 5, 1, 3, 1, 1, 1};
  localparam int          V_DIV  [NUM_VEC] = '{1, 2, 1, 1, 1, 0, 1, 1, 1, 1};
  localparam logic [4:0]  V_EN   [NUM_VEC] = '{5'h1F, 5'h1F, 5'h1F, 5'h1F, 5'h1F,
                                               5'h1F, 5'h1F, 5'h10, 5'h1F, 5'h02};
  localparam logic        V_MASK [NUM_VEC] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam int          V_TICK [NUM_VEC] = '{3, 8, 3, 16, 25, 9, 2, 5, 5, 2};
  localparam logic [4:0]  V_EXP  [NUM_VEC] = '{5'h01, 5'h07, 5'h07, 5'h0F, 5'h1F,
                                               5'h1F, 5'h00, 5'h10, 5'h1E, 5'h02};
  localparam string       V_REQ  [NUM_VEC] = '{"R5 R6", "R5 R6", "R6", "R6", "R6",
                                               "R12 R5", "R2", "R7", "R8", "R7"};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        usTick = 1'b0;
  logic        irqOut, fiqOut, remoteIrqOut, dbgResetOut, porResetOut;
  logic [4:0]  outVec;
  int checks = 0;
  int errors = 0;

  assign outVec = {porResetOut, dbgResetOut, remoteIrqOut, fiqOut, irqOut};

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_escalator u_wdt_escalator (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .usTick(usTick),
    .irqOut(irqOut), .fiqOut(fiqOut), .remoteIrqOut(remoteIrqOut),
    .dbgResetOut(dbgResetOut), .porResetOut(porResetOut)
  );

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busWrEn = 1'b0; usTick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      usTick = 1'b1;
      @(negedge clk);
      usTick = 1'b0;
    end
  endtask

  task automatic armWatchdog(input int per, input logic [31:0] cfgWord);
    busWrite(A_MASK, 32'h0001_0000);
    busWrite(A_TCTL, T_EN | T_PER | 32'(per));
    busWrite(A_CFG, cfgWord);
    busWrite(A_CMD, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog-timeout actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;

    // table walk
    for (int i = 0; i < NUM_VEC; i++) begin
      doReset();
      busWrite(A_MASK, V_MASK[i] ? 32'h0001_0000 : 32'h0);
      busWrite(A_TCTL, T_EN | T_PER | 32'(V_PER[i]));
      busWrite(A_CFG, (32'(V_EN[i]) << 12) | (32'(V_DIV[i]) << 4));
      busWrite(A_CMD, 32'h1);
      tick(V_TICK[i]);
      checkEq(V_REQ[i], $sformatf("vector %0d outputs", i), 32'(outVec), 32'(V_EXP[i]));
    end

    // R1 reset state
    doReset();
    checkEq("R1", "outputs after reset", 32'(outVec), 32'h0);
    busRead(A_CFG, rd);   checkEq("R1", "cfg reg", rd, 32'h0);
    busRead(A_TCTL, rd);  checkEq("R1", "timer ctrl", rd, 32'h0);
    busRead(A_TSTAT, rd); checkEq("R1", "timer status", rd, 32'h0);
    busRead(A_TSRC, rd);  checkEq("R1", "source select", rd, 32'h0);
    busRead(A_MASK, rd);  checkEq("R1", "mask reg", rd, 32'h0);

    // R2 timer period, status, clear; R3 periodic keeps enable
    busWrite(A_TCTL, T_EN | T_PER | 32'd4);
    tick(3);
    busRead(A_TSTAT, rd); checkEq("R2", "status before period", rd, 32'h0);
    tick(1);
    busRead(A_TSTAT, rd); checkEq("R2", "status at period", rd, 32'h4000_0000);
    busRead(A_TCTL, rd);  checkEq("R3", "periodic ctrl kept", rd, 32'hC000_0004);
    busWrite(A_TSTAT, 32'h4000_0000);
    busRead(A_TSTAT, rd); checkEq("R2", "status cleared", rd, 32'h0);

    // R3 one-shot disarms
    doReset();
    busWrite(A_TCTL, T_EN | 32'd2);
    tick(2);
    busRead(A_TCTL, rd);  checkEq("R3", "one-shot enable cleared", rd, 32'h0000_0002);
    busWrite(A_TSTAT, 32'h4000_0000);
    tick(4);
    busRead(A_TSTAT, rd); checkEq("R3", "no expiry after one-shot", rd, 32'h0);

    // R4 non-zero source ignores ticks
    doReset();
    busWrite(A_TSRC, 32'h1);
    busWrite(A_TCTL, T_EN | T_PER | 32'd1);
    tick(5);
    busRead(A_TSTAT, rd); checkEq("R4", "status with other source", rd, 32'h0);

    // R5 source index mismatch, and no start
    doReset();
    armWatchdog(1, ALL_EN | 32'h13);
    tick(5);
    checkEq("R5", "outputs with wd source 3", 32'(outVec), 32'h0);
    doReset();
    busWrite(A_MASK, 32'h0001_0000);
    busWrite(A_TCTL, T_EN | T_PER | 32'd1);
    busWrite(A_CFG, ALL_EN | 32'h10);
    tick(5);
    checkEq("R5", "outputs without start", 32'(outVec), 32'h0);

    // R9 locked disable ignored; R10 unlocked disable and restart
    doReset();
    armWatchdog(1, ALL_EN | 32'h10);
    tick(2);
    checkEq("R6", "stage 2 outputs", 32'(outVec), 32'h07);
    busWrite(A_CMD, 32'h2);
    checkEq("R9", "locked disable outputs", 32'(outVec), 32'h07);
    tick(2);
    checkEq("R9", "counting continues", 32'(outVec), 32'h0F);
    busWrite(A_UNLK, KEY);
    busWrite(A_CMD, 32'h2);
    checkEq("R10", "unlocked disable clears", 32'(outVec), 32'h0);
    tick(3);
    checkEq("R10", "stopped after disable", 32'(outVec), 32'h0);
    busWrite(A_CMD, 32'h1);
    tick(1);
    checkEq("R10", "restart at stage 1", 32'(outVec), 32'h01);

    // R10 pet in one write restarts the timer period
    doReset();
    armWatchdog(3, ALL_EN | 32'h10);
    tick(2);
    busWrite(A_UNLK, KEY);
    busWrite(A_CMD, 32'h3);
    tick(2);
    checkEq("R10", "timer count restarted", 32'(outVec), 32'h0);
    tick(1);
    checkEq("R10", "stage 1 after full period", 32'(outVec), 32'h01);

    // R11 unlock consumption and re-lock
    doReset();
    armWatchdog(1, ALL_EN | 32'h10);
    tick(1);
    busWrite(A_UNLK, KEY);
    busWrite(A_CMD, 32'h1);
    busWrite(A_CMD, 32'h2);
    checkEq("R11", "unlock consumed by start", 32'(outVec), 32'h01);
    busWrite(A_UNLK, KEY);
    busWrite(A_UNLK, 32'h0000_1234);
    busWrite(A_CMD, 32'h2);
    checkEq("R11", "wrong value re-locks", 32'(outVec), 32'h01);
    busWrite(A_UNLK, KEY);
    busWrite(A_CMD, 32'h2);
    checkEq("R11", "fresh unlock allows disable", 32'(outVec), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule